// File: doc/BRIEF.md
# Guarded Byte-Order-Aware Word Load Unit

This block is the 32-bit load path of a data-memory unit in a wide-issue processor. Each cycle it may take one load request made up of a guard operand, a byte address, a destination register index, the current byte-order mode bit, a cacheable flag and the identifier of the issue slot the operation came from. Legal requests with a true guard fetch four consecutive bytes through a four-lane byte-addressed memory read port. The unit assembles the bytes into a word in big-endian or little-endian lane order. Three cycles after issue it presents the word on a register writeback port, along with a data-cache status update strobe.

A window of addresses, set by inclusive base and limit inputs, marks the memory-mapped I/O region. Loads that fall inside it always use big-endian lane order, whatever the mode bit says. A false guard makes the load vanish: no memory request, no writeback and no cache update. Misaligned addresses raise no exception. They return the bytes at the literal computed addresses and raise a debug-only flag.

The issue side is a valid/ready stream. Ready is high whenever reset is low, so the unit never applies back-pressure and a load can issue every cycle. The writeback side has no ready: the register file must accept the result in the cycle it is presented.

Top module: `wload_unit`

## Requirements
- R1: When the order bit is 1 (little-endian) and the address is outside the aperture, the result for base address a is {m[a+3], m[a+2], m[a+1], m[a]}.
- R2: When the order bit is 0 (big-endian), the result is {m[a], m[a+1], m[a+2], m[a+3]}.
- R3: An address a with mmio_base <= a <= mmio_limit uses the R2 order even when the order bit is 1.
- R4: Only bit 0 of iss_guard matters. When it is 0 the load makes no memory request, produces no wb_valid and produces no cache_upd.
- R5: An issue is accepted when iss_valid and iss_ready are both high at a clock edge. An accepted issue with a true guard from a legal slot makes wb_valid high exactly 3 cycles later, and back-to-back issues each give their own result.
- R6: cache_upd is high in the same cycle as wb_valid exactly when the load was issued with iss_cacheable = 1, and it is never high without wb_valid.
- R7: Only slot identifiers 4 and 5 are legal. An accepted issue from any other slot makes no memory request and no writeback, and it raises slot_err for one cycle, one cycle after the issue.
- R8: A misaligned address (bits 1:0 not 00) returns the bytes at the literal addresses a to a+3 in the order chosen by R1 to R3. It also raises dbg_misalign together with wb_valid.
- R9: Synchronous active-high reset holds iss_ready low and clears every pipeline valid bit. While reset is high and in the 3 cycles after it, wb_valid, cache_upd and slot_err stay low, even for a load accepted just before reset.
- R10: wb_dest equals the destination index given with the issue that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Load request present |
| iss_ready | output | 1 | Unit accepts a request (high outside reset) |
| iss_guard | input | 32 | Guard operand; only bit 0 is used |
| iss_slot | input | SLOT_W | Issue slot identifier |
| iss_addr | input | ADDR_W | Byte base address |
| iss_dest | input | DEST_W | Destination register index |
| iss_order | input | 1 | Byte order: 1 little-endian, 0 big-endian |
| iss_cacheable | input | 1 | Addressed locations are cacheable |
| mmio_base | input | ADDR_W | Lowest address of the I/O aperture |
| mmio_limit | input | ADDR_W | Highest address of the I/O aperture |
| mem_req | output | 1 | Read request for the four lanes this cycle |
| mem_addr | output | 4*ADDR_W | Lane i address (base + i) at bits i*ADDR_W |
| mem_rdata | input | 32 | Lane i byte at bits 8i+7:8i, one cycle after mem_req |
| wb_valid | output | 1 | Writeback strobe |
| wb_dest | output | DEST_W | Writeback register index |
| wb_data | output | 32 | Loaded word |
| cache_upd | output | 1 | Data-cache status update strobe |
| slot_err | output | 1 | Issue from an illegal slot was seen |
| dbg_misalign | output | 1 | Debug flag: returned word came from a misaligned address |

## Verification
The bench builds the unit with a 12-bit address, a 7-bit destination index and the default legal slots 4 and 5. It fixes the aperture at 0x800 to 0x8FF. The small address space lets the memory model be a computed function of the address, so every expected word is derived directly from the R1 and R2 orderings. The fixed aperture puts both of its edges (0x7FC, 0x800, 0x8FC, 0x900) within a short table of back-to-back loads. Directed sequences then cover reset with a pending issue and a reset that lands on an accepted load in flight.

// File: rtl/wlu_pkg.sv
package wlu_pkg;
  typedef enum logic [0:0] {
    ORD_BIG    = 1'b0,
    ORD_LITTLE = 1'b1
  } byte_order_e;

  // Per-load control carried down the pipeline next to the data.
  typedef struct packed {
    logic cacheable;
    logic misalign;
    logic swap;
  } ld_flags_t;
endpackage

// File: rtl/wlu_issue_ctl.sv
module wlu_issue_ctl
  import wlu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SLOT_W  = 3,
  parameter int SLOT_LO = 4,
  parameter int SLOT_HI = 5,
  parameter int LANES   = 4
) (
  input  logic                    accept,
  input  logic                    guard_bit,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order,
  input  logic                    cacheable,
  input  logic [ADDR_W-1:0]       ap_base,
  input  logic [ADDR_W-1:0]       ap_limit,
  output logic                    go,
  output logic                    slot_bad,
  output ld_flags_t               flags,
  output logic [LANES*ADDR_W-1:0] lane_addr
);
  localparam int OFS_W = $clog2(LANES);

  logic        slot_ok;
  logic        in_aperture;
  byte_order_e ord;

  assign ord         = byte_order_e'(order);
  assign slot_ok     = (slot == SLOT_W'(SLOT_LO)) || (slot == SLOT_W'(SLOT_HI));
  assign in_aperture = (addr >= ap_base) && (addr <= ap_limit);

  assign go       = accept && guard_bit && slot_ok;
  assign slot_bad = accept && !slot_ok;

  assign flags.cacheable = cacheable;
  assign flags.misalign  = |addr[OFS_W-1:0];
  assign flags.swap      = (ord == ORD_LITTLE) && !in_aperture;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_addr[i*ADDR_W +: ADDR_W] = addr + ADDR_W'(i);
  end
endmodule

// File: rtl/wlu_lane_steer.sv
module wlu_lane_steer #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] raw,
  input  logic               swap,
  output logic [LANES*8-1:0] word
);
  // Result byte k takes lane (LANES-1-k) XOR (swap ? LANES-1 : 0).
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    localparam int BIG_SRC = LANES - 1 - k;
    localparam int LIT_SRC = BIG_SRC ^ (LANES - 1);
    assign word[k*8 +: 8] = swap ? raw[LIT_SRC*8 +: 8] : raw[BIG_SRC*8 +: 8];
  end
endmodule

// File: rtl/wload_unit.sv
module wload_unit
  import wlu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEST_W  = 7,
  parameter int SLOT_W  = 3,
  parameter int SLOT_LO = 4,
  parameter int SLOT_HI = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [31:0]         iss_guard,
  input  logic [SLOT_W-1:0]   iss_slot,
  input  logic [ADDR_W-1:0]   iss_addr,
  input  logic [DEST_W-1:0]   iss_dest,
  input  logic                iss_order,
  input  logic                iss_cacheable,
  input  logic [ADDR_W-1:0]   mmio_base,
  input  logic [ADDR_W-1:0]   mmio_limit,
  output logic                mem_req,
  output logic [4*ADDR_W-1:0] mem_addr,
  input  logic [31:0]         mem_rdata,
  output logic                wb_valid,
  output logic [DEST_W-1:0]   wb_dest,
  output logic [31:0]         wb_data,
  output logic                cache_upd,
  output logic                slot_err,
  output logic                dbg_misalign
);
  localparam int LANES  = 4;
  localparam int WORD_W = LANES * 8;

  logic      accept;
  logic      go;
  logic      slot_bad;
  ld_flags_t iss_flags;
  logic      guard_unused;

  assign iss_ready    = !rst;
  assign accept       = iss_valid && iss_ready;
  assign guard_unused = ^iss_guard[31:1];

  wlu_issue_ctl #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .SLOT_LO(SLOT_LO),
    .SLOT_HI(SLOT_HI),
    .LANES  (LANES)
  ) u_issue (
    .accept   (accept),
    .guard_bit(iss_guard[0]),
    .slot     (iss_slot),
    .addr     (iss_addr),
    .order    (iss_order),
    .cacheable(iss_cacheable),
    .ap_base  (mmio_base),
    .ap_limit (mmio_limit),
    .go       (go),
    .slot_bad (slot_bad),
    .flags    (iss_flags),
    .lane_addr(mem_addr)
  );

  assign mem_req = go;

  // Stage 1: memory access in flight.
  logic              s1_v;
  logic [DEST_W-1:0] s1_dest;
  ld_flags_t         s1_flags;
  logic              s1_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_err <= 1'b0;
    end else begin
      s1_v   <= go;
      s1_err <= slot_bad;
    end
    if (go) begin
      s1_dest  <= iss_dest;
      s1_flags <= iss_flags;
    end
  end

  assign slot_err = s1_err;

  // Stage 2: bytes returned, steered into a word.
  logic [WORD_W-1:0] steered;

  wlu_lane_steer #(.LANES(LANES)) u_steer (
    .raw (mem_rdata),
    .swap(s1_flags.swap),
    .word(steered)
  );

  logic              s2_v;
  logic [DEST_W-1:0] s2_dest;
  ld_flags_t         s2_flags;
  logic [WORD_W-1:0] s2_word;

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    if (s1_v) begin
      s2_dest  <= s1_dest;
      s2_flags <= s1_flags;
      s2_word  <= steered;
    end
  end

  // Stage 3: writeback registers.
  logic s3_v;
  logic s3_cache;
  logic s3_mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_v     <= 1'b0;
      s3_cache <= 1'b0;
      s3_mis   <= 1'b0;
    end else begin
      s3_v     <= s2_v;
      s3_cache <= s2_v && s2_flags.cacheable;
      s3_mis   <= s2_v && s2_flags.misalign;
    end
    if (s2_v) begin
      wb_dest <= s2_dest;
      wb_data <= s2_word;
    end
  end

  assign wb_valid     = s3_v;
  assign cache_upd    = s3_cache;
  assign dbg_misalign = s3_mis;
endmodule

// File: rtl/wlu_checker.sv
module wlu_checker #(
  parameter int DEST_W  = 7,
  parameter int SLOT_W  = 3,
  parameter int SLOT_LO = 4,
  parameter int SLOT_HI = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic              guard0,
  input logic [SLOT_W-1:0] iss_slot,
  input logic [DEST_W-1:0] iss_dest,
  input logic              iss_cacheable,
  input logic              mem_req,
  input logic              wb_valid,
  input logic [DEST_W-1:0] wb_dest,
  input logic              cache_upd,
  input logic              slot_err,
  input logic              dbg_misalign
);
  logic [1:0] since_rst;
  logic       legal;

  assign legal = (iss_slot == SLOT_W'(SLOT_LO)) || (iss_slot == SLOT_W'(SLOT_HI));

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r4_no_req_false_guard: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> guard0);

  a_r5_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (wb_valid == $past(mem_req, 3)));

  a_r6_cache_with_wb: assert property (@(posedge clk) disable iff (rst)
    cache_upd |-> wb_valid);

  a_r6_cache_follows_flag: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (cache_upd == $past(mem_req && iss_cacheable, 3)));

  a_r7_legal_slot_only: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> legal);

  a_r7_slot_flag: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) |-> (slot_err == $past(iss_valid && iss_ready && !legal)));

  a_r8_misalign_with_wb: assert property (@(posedge clk) disable iff (rst)
    dbg_misalign |-> wb_valid);

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wb_valid && !cache_upd && !slot_err));

  a_r10_dest_carried: assert property (@(posedge clk) disable iff (rst)
    ((since_rst == 2'd3) && wb_valid) |-> (wb_dest == $past(iss_dest, 3)));
endmodule

bind wload_unit wlu_checker #(
  .DEST_W (DEST_W),
  .SLOT_W (SLOT_W),
  .SLOT_LO(SLOT_LO),
  .SLOT_HI(SLOT_HI)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .iss_valid    (iss_valid),
  .iss_ready    (iss_ready),
  .guard0       (iss_guard[0]),
  .iss_slot     (iss_slot),
  .iss_dest     (iss_dest),
  .iss_cacheable(iss_cacheable),
  .mem_req      (mem_req),
  .wb_valid     (wb_valid),
  .wb_dest      (wb_dest),
  .cache_upd    (cache_upd),
  .slot_err     (slot_err),
  .dbg_misalign (dbg_misalign)
);

// File: tb/wload_unit_tb_top.sv
module wload_unit_tb_top;
  localparam int AW = 12;
  localparam int DW = 7;
  localparam int SW = 3;
  localparam logic [AW-1:0] AP_LO = 12'h800;
  localparam logic [AW-1:0] AP_HI = 12'h8FF;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          order;
    logic          guard;
    logic [SW-1:0] slot;
    logic          cache;
    logic [DW-1:0] dest;
  } vec_t;

  localparam int N = 12;
  localparam vec_t VECS [N] = '{
    '{12'h100, 1'b1, 1'b1, 3'd4, 1'b1, 7'd1},
    '{12'h100, 1'b0, 1'b1, 3'd5, 1'b0, 7'd2},
    '{12'h104, 1'b1, 1'b0, 3'd4, 1'b1, 7'd3},
    '{12'h108, 1'b0, 1'b1, 3'd4, 1'b1, 7'd4},
    '{12'h7FC, 1'b1, 1'b1, 3'd5, 1'b1, 7'd5},
    '{12'h800, 1'b1, 1'b1, 3'd4, 1'b0, 7'd6},
    '{12'h8FC, 1'b1, 1'b1, 3'd4, 1'b0, 7'd7},
    '{12'h900, 1'b1, 1'b1, 3'd4, 1'b1, 7'd8},
    '{12'h201, 1'b1, 1'b1, 3'd4, 1'b1, 7'd9},
    '{12'h202, 1'b0, 1'b1, 3'd5, 1'b0, 7'd10},
    '{12'h300, 1'b1, 1'b1, 3'd3, 1'b1, 7'd11},
    '{12'h304, 1'b0, 1'b1, 3'd0, 1'b1, 7'd12}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [31:0]   iss_guard = '0;
  logic [SW-1:0] iss_slot = '0;
  logic [AW-1:0] iss_addr = '0;
  logic [DW-1:0] iss_dest = '0;
  logic          iss_order = 1'b0;
  logic          iss_cacheable = 1'b0;
  logic          mem_req;
  logic [4*AW-1:0] mem_addr;
  logic [31:0]   mem_rdata = '0;
  logic          wb_valid;
  logic [DW-1:0] wb_dest;
  logic [31:0]   wb_data;
  logic          cache_upd;
  logic          slot_err;
  logic          dbg_misalign;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  wload_unit #(.ADDR_W(AW), .DEST_W(DW), .SLOT_W(SW)) dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_guard(iss_guard), .iss_slot(iss_slot), .iss_addr(iss_addr),
    .iss_dest(iss_dest), .iss_order(iss_order), .iss_cacheable(iss_cacheable),
    .mmio_base(AP_LO), .mmio_limit(AP_HI), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wb_valid(wb_valid),
    .wb_dest(wb_dest), .wb_data(wb_data), .cache_upd(cache_upd),
    .slot_err(slot_err), .dbg_misalign(dbg_misalign)
  );

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd37 + 16'(a >> 4) + 16'h5A;
    return t[7:0];
  endfunction

  // Synchronous byte memory: data one cycle after the request.
  always_ff @(posedge clk) begin
    if (mem_req)
      for (int i = 0; i < 4; i++) mem_rdata[i*8 +: 8] <= mbyte(mem_addr[i*AW +: AW]);
  end

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a, input logic le);
    logic big;
    big = !le || (a >= AP_LO && a <= AP_HI);
    if (big) return {mbyte(a), mbyte(a + 12'd1), mbyte(a + 12'd2), mbyte(a + 12'd3)};
    else     return {mbyte(a + 12'd3), mbyte(a + 12'd2), mbyte(a + 12'd1), mbyte(a)};
  endfunction

  function automatic string data_tag(input vec_t v);
    if (v.addr[1:0] != 2'b00)              return "R8";
    if (v.addr >= AP_LO && v.addr <= AP_HI) return "R3";
    if (v.order)                            return "R1";
    return "R2";
  endfunction

  function automatic bit legal(input logic [SW-1:0] s);
    return (s == 3'd4) || (s == 3'd5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    iss_valid     = 1'b1;
    iss_addr      = v.addr;
    iss_order     = v.order;
    iss_guard     = v.guard ? 32'hA5A5_0001 : 32'hFFFF_FFFE;
    iss_slot      = v.slot;
    iss_cacheable = v.cache;
    iss_dest      = v.dest;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R5: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state with a pending request.
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    #1;
    chk(iss_ready == 1'b0, "R9", "iss_ready in reset", 32'(iss_ready), 32'd0);
    chk(mem_req == 1'b0, "R9", "mem_req in reset", 32'(mem_req), 32'd0);
    chk(wb_valid == 1'b0 && cache_upd == 1'b0, "R9", "wb/cache in reset",
        {30'd0, wb_valid, cache_upd}, 32'd0);
    chk(slot_err == 1'b0, "R9", "slot_err in reset", 32'(slot_err), 32'd0);
    @(negedge clk);
    iss_valid = 1'b0;
    rst = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(wb_valid == 1'b0, "R9", "wb_valid after reset", 32'(wb_valid), 32'd0);
    end

    // Table walk: one issue per cycle, results 3 cycles later (R5).
    for (int i = 0; i < N + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        vec_t v;
        bit   ev;
        v  = VECS[i-3];
        ev = v.guard && legal(v.slot);
        chk(wb_valid == ev, ev ? "R5" : (v.guard ? "R7" : "R4"), "wb_valid",
            32'(wb_valid), 32'(ev));
        if (ev) begin
          chk(wb_data == exp_word(v.addr, v.order), data_tag(v), "wb_data",
              wb_data, exp_word(v.addr, v.order));
          chk(wb_dest == v.dest, "R10", "wb_dest", 32'(wb_dest), 32'(v.dest));
          chk(cache_upd == v.cache, "R6", "cache_upd", 32'(cache_upd), 32'(v.cache));
          chk(dbg_misalign == (v.addr[1:0] != 2'b00), "R8", "dbg_misalign",
              32'(dbg_misalign), 32'(v.addr[1:0] != 2'b00));
        end else begin
          chk(cache_upd == 1'b0, "R4", "cache_upd suppressed", 32'(cache_upd), 32'd0);
        end
      end
      if (i >= 1 && i - 1 < N) begin
        chk(slot_err == !legal(VECS[i-1].slot), "R7", "slot_err",
            32'(slot_err), 32'(!legal(VECS[i-1].slot)));
      end
      if (i < N) begin
        drive(VECS[i]);
        #1;
        chk(mem_req == (VECS[i].guard && legal(VECS[i].slot)),
            VECS[i].guard ? "R7" : "R4", "mem_req", 32'(mem_req),
            32'(VECS[i].guard && legal(VECS[i].slot)));
      end else begin
        iss_valid = 1'b0;
      end
    end

    // R9: reset lands on an accepted load in flight.
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    iss_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(wb_valid == 1'b0 && cache_upd == 1'b0, "R9", "in-flight load dropped",
          {30'd0, wb_valid, cache_upd}, 32'd0);
    end

    // R4: false guard from legal slot with cacheable set, isolated.
    @(negedge clk);
    drive(VECS[2]);
    @(negedge clk);
    iss_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(wb_valid == 1'b0 && cache_upd == 1'b0, "R4", "false guard isolated",
          {30'd0, wb_valid, cache_upd}, 32'd0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule